// File: doc/BRIEF.md
# Segment Display Update Status Controller

This block holds the status flags and the update handshake of a segment-display controller. Software sees an enabled-status flag, a start-of-frame flag, an update-request flag, an update-done flag, a frame-control synchronization flag and a step-up-converter ready flag. The block combines these with two interrupt enables into one interrupt line. A set/clear port carries the software actions: request an update, clear start-of-frame, clear update-done, and write the frame-control register.

An update request copies the first-level display RAM into the second-level buffer that drives the glass. While the display is off, the copy runs at once over every row. The request then stays pending, because only an enabled controller may retire it. While the display is on, the copy waits for the next frame-start strobe. It then moves only the rows of the commons that the duty code makes active. The RAM is read combinationally. The buffer side is a valid/ready write stream. Throughout the request, software writes to the first-level RAM are blocked.

Top module: `seg_upd_status`

## Requirements
- R1: `st_enabled` goes high in the same cycle that `ctl_enable` goes high. After `ctl_enable` falls it stays high, and it drops in the cycle after the first `frame_start` strobe sampled while `ctl_enable` is low.
- R2: `st_sof` is set on a clock edge where `frame_start` is high and `st_enabled` is high. It is cleared on an edge where `clr_sof` is high, and the clear wins when both happen on the same edge. A `frame_start` while disabled does not set it.
- R3: An edge with `upd_wr`=1 and `upd_wr_val`=1 sets `st_upd_req`. A write of 0, or a write of 1 while the flag is already set, changes nothing and does not restart a copy in progress. The flag is cleared only by the block itself, at the end of a copy that finishes while `st_enabled` is high.
- R4: While `st_upd_req` is high, `ram_wr_en` is low whatever `ram_wr_req` does. Otherwise `ram_wr_en` equals `ram_wr_req`.
- R5: While enabled, a pending request waits for the next `frame_start` strobe. It then writes buffer rows 0 up to a last row that depends on `duty`: code 0 gives row 0, 1 gives 1, 2 gives 2, 3 gives 3, and 4 through 7 give 7, clamped to ROWS-1. The block writes one row per accepted beat, in ascending order, and clears `st_upd_req` in the cycle after the last beat.
- R6: While disabled, a pending request starts a copy of all ROWS rows in the cycle after the flag is seen. When that copy ends, `st_upd_req` stays high and `st_upd_done` stays low. Once the display is enabled, the request is served again as in R5.
- R7: Buffer stream: a beat transfers on an edge where `buf_wr_valid` and `buf_wr_ready` are both high. While `buf_wr_ready` is low, `buf_wr_valid`, `buf_wr_addr` and `buf_wr_data` hold. `buf_wr_data` equals `ram_rd_data` while `ram_rd_addr` equals `buf_wr_addr`.
- R8: `st_upd_done` is set in the same cycle that `st_upd_req` is cleared. `clr_udd` clears it, but a simultaneous set wins.
- R9: `irq` is high when (`st_sof` and `sof_ie`) or (`st_upd_done` and `udd_ie` and `st_enabled`). The update-done source never asserts while disabled.
- R10: `st_fcr_synced` resets low. It is set one cycle after `fcr_sync_ack`, and it is cleared one cycle after `fcr_wr`. The write wins over a simultaneous acknowledge.
- R11: `st_ready` follows `step_ready` one cycle later and has no software write path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Display enable control bit |
| upd_wr | input | 1 | Write strobe to the update-request bit |
| upd_wr_val | input | 1 | Value written with `upd_wr` |
| clr_sof | input | 1 | Clear strobe for the start-of-frame flag |
| clr_udd | input | 1 | Clear strobe for the update-done flag |
| fcr_wr | input | 1 | Software write of the frame-control register |
| fcr_sync_ack | input | 1 | Frame-control value captured in display clock domain |
| frame_start | input | 1 | Frame-start strobe |
| duty | input | 3 | Duty code |
| step_ready | input | 1 | Step-up converter ready |
| sof_ie | input | 1 | Start-of-frame interrupt enable |
| udd_ie | input | 1 | Update-done interrupt enable |
| ram_wr_req | input | 1 | Software write request to first-level RAM |
| ram_wr_en | output | 1 | Gated first-level RAM write enable |
| ram_rd_addr | output | ROW_W | First-level RAM read row |
| ram_rd_data | input | DATA_W | First-level RAM read data (same cycle) |
| buf_wr_valid | output | 1 | Buffer write beat valid |
| buf_wr_ready | input | 1 | Buffer accepts the beat |
| buf_wr_addr | output | ROW_W | Buffer row written |
| buf_wr_data | output | DATA_W | Buffer row data |
| st_enabled | output | 1 | Enabled-status flag |
| st_sof | output | 1 | Start-of-frame flag |
| st_upd_req | output | 1 | Update-request flag |
| st_upd_done | output | 1 | Update-done flag |
| st_ready | output | 1 | Step-up ready flag |
| st_fcr_synced | output | 1 | Frame-control synchronized flag |
| irq | output | 1 | Combined interrupt |

## Verification
The copy is tried with every distinct duty code, and with one reserved code. Each run has a fixed row count, so a wrong decode or a wrong clamp shows up as a count error. Some of these runs stall `buf_wr_ready` on alternate cycles, which separates beat-driven row stepping from clock-driven stepping. A copy requested while disabled, followed by enabling, separates the full-row path from the active-row path and shows that the request survives. Strobes on the same edge (frame start with start-of-frame clear, completion with done clear, frame-control write with acknowledge) tell the two priority orders apart.

// File: rtl/seg_stat_pkg.sv
package seg_stat_pkg;
  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WAIT = 2'd1,
    CP_COPY = 2'd2,
    CP_HELD = 2'd3
  } copy_state_e;

  localparam int DUTY_W = 3;
endpackage

// File: rtl/seg_duty_decode.sv
module seg_duty_decode #(
  parameter int ROWS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic [seg_stat_pkg::DUTY_W-1:0] duty_i,
  output logic [ROW_W-1:0]                last_o
);
  localparam int TOP_ROW = ROWS - 1;

  int raw_last;

  always_comb begin
    case (duty_i)
      3'd0:    raw_last = 0;
      3'd1:    raw_last = 1;
      3'd2:    raw_last = 2;
      3'd3:    raw_last = 3;
      default: raw_last = 7;
    endcase
    if (raw_last > TOP_ROW) raw_last = TOP_ROW;
    last_o = ROW_W'(raw_last);
  end
endmodule

// File: rtl/seg_copy_engine.sv
module seg_copy_engine
  import seg_stat_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              frame_start_i,
  input  logic              req_wr_i,
  input  logic [ROW_W-1:0]  active_last_i,
  input  logic              ram_wr_req_i,
  output logic              ram_wr_en_o,
  output logic [ROW_W-1:0]  ram_rd_addr_o,
  input  logic [DATA_W-1:0] ram_rd_data_i,
  output logic              buf_wr_valid_o,
  input  logic              buf_wr_ready_i,
  output logic [ROW_W-1:0]  buf_wr_addr_o,
  output logic [DATA_W-1:0] buf_wr_data_o,
  output logic              upd_req_o,
  output logic              done_set_o
);
  localparam logic [ROW_W-1:0] ALL_LAST = ROW_W'(ROWS - 1);

  copy_state_e      state_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_q;
  logic             full_q;
  logic             req_q;
  logic             beat;
  logic             at_last;

  assign beat    = (state_q == CP_COPY) && buf_wr_ready_i;
  assign at_last = (row_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      row_q   <= '0;
      last_q  <= '0;
      full_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (req_wr_i && !req_q) req_q <= 1'b1;
      case (state_q)
        CP_IDLE: begin
          if (req_q) begin
            if (en_i) begin
              state_q <= CP_WAIT;
            end else begin
              state_q <= CP_COPY;
              row_q   <= '0;
              last_q  <= ALL_LAST;
              full_q  <= 1'b1;
            end
          end
        end
        CP_WAIT: begin
          if (!en_i) begin
            state_q <= CP_IDLE;
          end else if (frame_start_i) begin
            state_q <= CP_COPY;
            row_q   <= '0;
            last_q  <= active_last_i;
            full_q  <= 1'b0;
          end
        end
        CP_COPY: begin
          if (beat) begin
            if (at_last) begin
              if (full_q || !en_i) begin
                state_q <= CP_HELD;
              end else begin
                state_q <= CP_IDLE;
                req_q   <= 1'b0;
              end
            end else begin
              row_q <= row_q + 1'b1;
            end
          end
        end
        CP_HELD: begin
          if (en_i) state_q <= CP_WAIT;
        end
        default: state_q <= CP_IDLE;
      endcase
    end
  end

  assign done_set_o     = beat && at_last && !full_q && en_i;
  assign upd_req_o      = req_q;
  assign ram_wr_en_o    = ram_wr_req_i && !req_q;
  assign ram_rd_addr_o  = row_q;
  assign buf_wr_valid_o = (state_q == CP_COPY);
  assign buf_wr_addr_o  = row_q;
  assign buf_wr_data_o  = ram_rd_data_i;

  AST_REQ_DROP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(en_i)); // R3
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_valid_o |-> (buf_wr_addr_o <= last_q)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_valid_o && !buf_wr_ready_i) |=> (buf_wr_valid_o && $stable(buf_wr_addr_o))); // R7
  AST_RAM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && $past(req_q)) |-> !ram_wr_en_o); // R4
endmodule

// File: rtl/seg_flag_regs.sv
module seg_flag_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_enable_i,
  input  logic frame_start_i,
  input  logic clr_sof_i,
  input  logic clr_udd_i,
  input  logic done_set_i,
  input  logic fcr_wr_i,
  input  logic fcr_sync_ack_i,
  input  logic step_ready_i,
  input  logic sof_ie_i,
  input  logic udd_ie_i,
  output logic enabled_o,
  output logic sof_o,
  output logic udd_o,
  output logic fsync_o,
  output logic ready_o,
  output logic irq_o
);
  logic hold_q;
  logic sof_q;
  logic udd_q;
  logic fsync_q;
  logic rdy_q;

  assign enabled_o = ctl_enable_i || hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      sof_q   <= 1'b0;
      udd_q   <= 1'b0;
      fsync_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      if (ctl_enable_i)       hold_q <= 1'b1;
      else if (frame_start_i) hold_q <= 1'b0;

      if (clr_sof_i)                       sof_q <= 1'b0;
      else if (frame_start_i && enabled_o) sof_q <= 1'b1;

      if (done_set_i)     udd_q <= 1'b1;
      else if (clr_udd_i) udd_q <= 1'b0;

      if (fcr_wr_i)            fsync_q <= 1'b0;
      else if (fcr_sync_ack_i) fsync_q <= 1'b1;

      rdy_q <= step_ready_i;
    end
  end

  assign sof_o   = sof_q;
  assign udd_o   = udd_q;
  assign fsync_o = fsync_q;
  assign ready_o = rdy_q;
  assign irq_o   = (sof_q && sof_ie_i) || (udd_q && udd_ie_i && enabled_o);

  AST_SOF_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sof_i |=> !sof_o); // R2
  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_i |=> udd_o); // R8
  AST_FCR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr_i |=> !fsync_o); // R10
  AST_ENS_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled_o) |-> $past(frame_start_i) && !ctl_enable_i); // R1
  AST_NO_DONE_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !enabled_o) |-> (sof_o && sof_ie_i)); // R9
endmodule

// File: rtl/seg_upd_status.sv
module seg_upd_status
  import seg_stat_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              upd_wr,
  input  logic              upd_wr_val,
  input  logic              clr_sof,
  input  logic              clr_udd,
  input  logic              fcr_wr,
  input  logic              fcr_sync_ack,
  input  logic              frame_start,
  input  logic [2:0]        duty,
  input  logic              step_ready,
  input  logic              sof_ie,
  input  logic              udd_ie,
  input  logic              ram_wr_req,
  output logic              ram_wr_en,
  output logic [ROW_W-1:0]  ram_rd_addr,
  input  logic [DATA_W-1:0] ram_rd_data,
  output logic              buf_wr_valid,
  input  logic              buf_wr_ready,
  output logic [ROW_W-1:0]  buf_wr_addr,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              st_enabled,
  output logic              st_sof,
  output logic              st_upd_req,
  output logic              st_upd_done,
  output logic              st_ready,
  output logic              st_fcr_synced,
  output logic              irq
);
  logic [ROW_W-1:0] active_last;
  logic             done_set;
  logic             req_wr;

  assign req_wr = upd_wr && upd_wr_val;

  seg_duty_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) duty_dec_i (
    .duty_i (duty),
    .last_o (active_last)
  );

  seg_copy_engine #(.ROWS(ROWS), .DATA_W(DATA_W), .ROW_W(ROW_W)) copy_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (st_enabled),
    .frame_start_i  (frame_start),
    .req_wr_i       (req_wr),
    .active_last_i  (active_last),
    .ram_wr_req_i   (ram_wr_req),
    .ram_wr_en_o    (ram_wr_en),
    .ram_rd_addr_o  (ram_rd_addr),
    .ram_rd_data_i  (ram_rd_data),
    .buf_wr_valid_o (buf_wr_valid),
    .buf_wr_ready_i (buf_wr_ready),
    .buf_wr_addr_o  (buf_wr_addr),
    .buf_wr_data_o  (buf_wr_data),
    .upd_req_o      (st_upd_req),
    .done_set_o     (done_set)
  );

  seg_flag_regs flags_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_enable_i   (ctl_enable),
    .frame_start_i  (frame_start),
    .clr_sof_i      (clr_sof),
    .clr_udd_i      (clr_udd),
    .done_set_i     (done_set),
    .fcr_wr_i       (fcr_wr),
    .fcr_sync_ack_i (fcr_sync_ack),
    .step_ready_i   (step_ready),
    .sof_ie_i       (sof_ie),
    .udd_ie_i       (udd_ie),
    .enabled_o      (st_enabled),
    .sof_o          (st_sof),
    .udd_o          (st_upd_done),
    .fsync_o        (st_fcr_synced),
    .ready_o        (st_ready),
    .irq_o          (irq)
  );

  AST_DONE_WITH_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_upd_req) |-> st_upd_done); // R8
  AST_ENABLE_RISE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_enable) |-> st_enabled); // R1
endmodule

// File: tb/seg_upd_status_tb_top.sv
module seg_upd_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 8;
  localparam int DATA_W = 32;
  localparam int ROW_W  = 3;
  localparam int NVEC   = 6;

  localparam logic [2:0] VEC_DUTY  [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
  localparam int         VEC_ROWS  [NVEC] = '{1, 2, 3, 4, 8, 8};
  localparam logic       VEC_STALL [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_enable = 0, upd_wr = 0, upd_wr_val = 0, clr_sof = 0, clr_udd = 0;
  logic fcr_wr = 0, fcr_sync_ack = 0, frame_start = 0, step_ready = 0;
  logic sof_ie = 0, udd_ie = 0, ram_wr_req = 0, buf_wr_ready = 1;
  logic [2:0] duty = 3'd0;
  logic ram_wr_en, buf_wr_valid;
  logic [ROW_W-1:0] ram_rd_addr, buf_wr_addr;
  logic [DATA_W-1:0] ram_rd_data, buf_wr_data;
  logic st_enabled, st_sof, st_upd_req, st_upd_done, st_ready, st_fcr_synced, irq;

  int n_chk = 0;
  int n_bad = 0;
  int beats = 0;
  int exp_idx = 0;
  logic stall_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ram_rd_data = {24'hC0FFEE, 5'd0, ram_rd_addr};

  seg_upd_status #(.ROWS(ROWS), .DATA_W(DATA_W), .ROW_W(ROW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .upd_wr(upd_wr),
    .upd_wr_val(upd_wr_val), .clr_sof(clr_sof), .clr_udd(clr_udd),
    .fcr_wr(fcr_wr), .fcr_sync_ack(fcr_sync_ack), .frame_start(frame_start),
    .duty(duty), .step_ready(step_ready), .sof_ie(sof_ie), .udd_ie(udd_ie),
    .ram_wr_req(ram_wr_req), .ram_wr_en(ram_wr_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_rd_data), .buf_wr_valid(buf_wr_valid),
    .buf_wr_ready(buf_wr_ready), .buf_wr_addr(buf_wr_addr),
    .buf_wr_data(buf_wr_data), .st_enabled(st_enabled), .st_sof(st_sof),
    .st_upd_req(st_upd_req), .st_upd_done(st_upd_done), .st_ready(st_ready),
    .st_fcr_synced(st_fcr_synced), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (stall_mode) buf_wr_ready = ~buf_wr_ready;
  endtask

  // R7: beats in order, data taken from the RAM row being written
  always @(negedge clk) begin
    if (rst_n && buf_wr_valid && buf_wr_ready) begin
      chk("R7 beat row order", 32'(buf_wr_addr), 32'(exp_idx));
      chk("R7 beat data", buf_wr_data, {24'hC0FFEE, 5'd0, buf_wr_addr});
      exp_idx++;
      beats++;
    end
  end

  task automatic request();
    upd_wr = 1; upd_wr_val = 1;
    step();
    upd_wr = 0; upd_wr_val = 0;
  endtask

  task automatic pulse_frame();
    frame_start = 1;
    step();
    frame_start = 0;
  endtask

  task automatic wait_req_clear(output int cyc);
    cyc = 0;
    while (st_upd_req && cyc < 60) begin
      step();
      cyc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) step();
    rst_n = 1;
    step();
    // reset state
    chk("R1 reset enabled", 32'(st_enabled), 0);
    chk("R2 reset sof", 32'(st_sof), 0);
    chk("R3 reset req", 32'(st_upd_req), 0);
    chk("R8 reset done", 32'(st_upd_done), 0);
    chk("R10 reset synced", 32'(st_fcr_synced), 0);
    chk("R11 reset ready", 32'(st_ready), 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R7 reset valid", 32'(buf_wr_valid), 0);

    // R11: ready follows input one cycle later
    step_ready = 1;
    #1 chk("R11 ready not yet", 32'(st_ready), 0);
    step();
    chk("R11 ready follows", 32'(st_ready), 1);

    // R10: sync flag
    fcr_sync_ack = 1; step(); fcr_sync_ack = 0;
    chk("R10 ack sets", 32'(st_fcr_synced), 1);
    fcr_wr = 1; fcr_sync_ack = 1; step(); fcr_wr = 0; fcr_sync_ack = 0;
    chk("R10 write wins", 32'(st_fcr_synced), 0);

    // R2: frame while disabled sets nothing
    pulse_frame();
    chk("R2 no sof when disabled", 32'(st_sof), 0);

    // R1: enable status
    ctl_enable = 1;
    #1 chk("R1 same-cycle rise", 32'(st_enabled), 1);
    step();
    ctl_enable = 0;
    step(); step();
    chk("R1 held after clear", 32'(st_enabled), 1);
    pulse_frame();
    chk("R1 drops after frame", 32'(st_enabled), 0);
    clr_sof = 1; step(); clr_sof = 0;

    // Vector table: enabled copies per duty code
    ctl_enable = 1; udd_ie = 1;
    step();
    for (int v = 0; v < NVEC; v++) begin
      duty = VEC_DUTY[v];
      beats = 0; exp_idx = 0;
      request();
      chk("R3 request sets", 32'(st_upd_req), 1);
      step();
      chk("R5 waits for frame", 32'(buf_wr_valid), 0);
      stall_mode = VEC_STALL[v];
      pulse_frame();
      chk("R2 sof at frame", 32'(st_sof), 1);
      clr_sof = 1; step(); clr_sof = 0;
      wait_req_clear(cyc);
      stall_mode = 0; buf_wr_ready = 1;
      chk("R5 rows for duty", 32'(beats), 32'(VEC_ROWS[v]));
      chk("R8 done set", 32'(st_upd_done), 1);
      chk("R9 done irq", 32'(irq), 1);
      clr_udd = 1; step(); clr_udd = 0;
      chk("R8 done cleared", 32'(st_upd_done), 0);
    end

    // R3: write 0 no effect, repeat write does not restart
    duty = 3'd3;
    upd_wr = 1; upd_wr_val = 0; step(); upd_wr = 0;
    chk("R3 write zero ignored", 32'(st_upd_req), 0);
    beats = 0; exp_idx = 0;
    request(); step();
    pulse_frame();
    step();
    request();
    chk("R3 repeat write keeps flag", 32'(st_upd_req), 1);
    wait_req_clear(cyc);
    chk("R3 no restart", 32'(beats), 4);
    step(); step();
    chk("R3 no second copy", 32'(beats), 4);

    // R8: set wins over simultaneous clear
    beats = 0; exp_idx = 0;
    clr_udd = 1;
    request(); step(); pulse_frame();
    wait_req_clear(cyc);
    chk("R8 set wins", 32'(st_upd_done), 1);
    clr_udd = 0;
    clr_sof = 1; step(); clr_sof = 0;

    // R2: clear wins over simultaneous frame
    sof_ie = 1;
    frame_start = 1; clr_sof = 1; step(); frame_start = 0; clr_sof = 0;
    chk("R2 clear wins", 32'(st_sof), 0);
    pulse_frame();
    chk("R9 sof irq", 32'(irq), 1);
    clr_sof = 1; step(); clr_sof = 0; sof_ie = 0;

    // R9: done irq masked once disabled, flag kept
    ctl_enable = 0; step(); pulse_frame();
    chk("R9 done flag kept", 32'(st_upd_done), 1);
    chk("R9 no done irq disabled", 32'(irq), 0);
    clr_udd = 1; step(); clr_udd = 0;

    // R6/R4: disabled full copy
    beats = 0; exp_idx = 0; duty = 3'd1;
    ram_wr_req = 1;
    #1 chk("R4 write passes idle", 32'(ram_wr_en), 1);
    request();
    chk("R4 write blocked", 32'(ram_wr_en), 0);
    repeat (15) step();
    chk("R6 all rows copied", 32'(beats), ROWS);
    chk("R6 request held", 32'(st_upd_req), 1);
    chk("R6 no done", 32'(st_upd_done), 0);
    chk("R4 still blocked", 32'(ram_wr_en), 0);
    beats = 0; exp_idx = 0;
    ctl_enable = 1;
    repeat (3) step();
    chk("R6 waits for frame", 32'(beats), 0);
    pulse_frame();
    wait_req_clear(cyc);
    chk("R6 active rows after enable", 32'(beats), 2);
    chk("R6 done after enable", 32'(st_upd_done), 1);
    chk("R4 write released", 32'(ram_wr_en), 1);
    ram_wr_req = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule